// File: doc/BRIEF.md
# I2C Bit-Clock Generator

This block derives the SCL timing base of an I2C master from a fast system clock. A baud byte selects the rate through two fields: a 3-bit exponent N and a 4-bit linear factor M. A two-stage prescaler divides the system clock first by 2^N and then by M+1. Each time both stages wrap, the block emits one tick. Ten ticks make one SCL bit period, so the SCL frequency is fclk / (10 × (M+1) × 2^N).

Within each bit period the block issues single-cycle strobes at fixed ticks. The byte engine uses them to pull SCL low, to change SDA, to release SCL high and to sample SDA. While the run enable is low the counters sit at zero and nothing is emitted. A new baud byte is taken either while idle or at the end of the last tick of a bit period, so a period never mixes two rates.

Top module: `i2cBitClockGen`

## Requirements
- R1: With the baud byte holding M in bits 6:3 and N in bits 2:0, consecutive ticks are exactly P = (M+1) × 2^N system clocks apart. The first tick after enable comes P clocks after the first enabled edge.
- R2: Bit 7 of the baud byte has no effect on the rate. For example, 0x80 gives the same P as 0x00.
- R3: Ticks are numbered 0 to 9 within a bit period, starting at tick 0 after enable. The SCL-low strobe marks tick 0, the SDA-change strobe tick 2, the SCL-high strobe tick 5 and the SDA-sample strobe tick 7. Each strobe is high for one clock, in the clock after the tick's edge, so they fall P, 3P, 6P and 8P clocks after enable. The next SCL-low strobe falls at 11P.
- R4: After reset the active setting is 0x44 (M=8, N=4, P=144) until a new byte is taken.
- R5: A baud byte that changes while running is taken only at tick 9 of the current bit period. The following tick 0 already uses the new P.
- R6: While the run enable is low, no strobe is produced and the prescaler and tick counter are held at zero. On re-enable the sequence restarts at tick 0 with the full P.
- R7: At most one strobe is high in any clock.
- R8: During reset all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| baudByte | input | 8 | Rate setting: M in bits 6:3, N in bits 2:0 |
| runEn | input | 1 | Run enable for the generator |
| sclLowStb | output | 1 | Tick 0 strobe: drive SCL low |
| sdaChangeStb | output | 1 | Tick 2 strobe: SDA may change |
| sclHighStb | output | 1 | Tick 5 strobe: release SCL high |
| sdaSampleStb | output | 1 | Tick 7 strobe: sample SDA |

## Verification
The hardest case to reach from the ports is a baud change landing inside a running bit period. The old rate must hold through tick 9, and the very next tick 0 must use the new rate. The bench changes the byte a few clocks after enable, at the fastest rate, and times the second SCL-low and SDA-change strobes. A second hard case is the reset value, which can only be observed if the enable is already high as reset releases. The bench therefore holds the enable high through reset with a different byte on the input.

// File: rtl/i2cClkPkg.sv
package i2cClkPkg;
  localparam int BAUD_W = 8;
  localparam int M_W    = 4;
  localparam int N_W    = 3;

  // command from sequencer to prescaler
  typedef struct packed {
    logic run;
    logic clear;
  } prescaleCmd_t;

  // phase strobes leaving the block
  typedef struct packed {
    logic sclLow;
    logic sdaChange;
    logic sclHigh;
    logic sdaSample;
  } phaseStb_t;
endpackage

// File: rtl/i2cClkPrescale.sv
module i2cClkPrescale
  import i2cClkPkg::*;
#(
  parameter int MW = M_W,
  parameter int NW = N_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  prescaleCmd_t  cmd,
  input  logic [MW-1:0] mSel,
  input  logic [NW-1:0] nSel,
  output logic          tick
);
  localparam int EXP_W = (1 << NW) - 1;

  logic [EXP_W-1:0] expCnt;
  logic [MW-1:0]    linCnt;
  logic [EXP_W:0]   expLimitWide;
  logic [EXP_W-1:0] expLimit;
  logic             expWrap;
  logic             linWrap;

  // exponential stage limit: 2^N - 1
  assign expLimitWide = ({{EXP_W{1'b0}}, 1'b1} << nSel) - 1'b1;
  assign expLimit     = expLimitWide[EXP_W-1:0];
  assign expWrap      = (expCnt == expLimit);
  assign linWrap      = (linCnt == mSel);
  assign tick         = cmd.run && expWrap && linWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expCnt <= '0;
      linCnt <= '0;
    end else if (cmd.clear) begin
      expCnt <= '0;
      linCnt <= '0;
    end else if (cmd.run) begin
      if (expWrap) begin
        expCnt <= '0;
        linCnt <= linWrap ? '0 : linCnt + 1'b1;
      end else begin
        expCnt <= expCnt + 1'b1;
      end
    end
  end

  // R6: a cleared prescaler starts from zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (expCnt == '0 && linCnt == '0));
  // R1: after a tick both stages restart
  a_r1_tick_restart: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cmd.clear) |=> (expCnt == '0 && linCnt == '0));
endmodule

// File: rtl/i2cClkSeq.sv
module i2cClkSeq
  import i2cClkPkg::*;
#(
  parameter int          MW         = M_W,
  parameter int          NW         = N_W,
  parameter int          PHASES     = 10,
  parameter int          LOW_PH     = 0,
  parameter int          CHG_PH     = 2,
  parameter int          HIGH_PH    = 5,
  parameter int          SMP_PH     = 7,
  parameter logic [7:0]  RESET_BAUD = 8'h44
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    baudIn,
  input  logic          runEn,
  input  logic          tick,
  output prescaleCmd_t  cmd,
  output logic [MW-1:0] mSel,
  output logic [NW-1:0] nSel,
  output phaseStb_t     stb
);
  localparam int PH_W    = $clog2(PHASES);
  localparam int LAST_PH = PHASES - 1;
  localparam int SET_W   = MW + NW;

  logic [SET_W-1:0] setting;
  logic [PH_W-1:0]  phase;
  logic             lastTick;
  logic             loadNow;

  assign lastTick  = tick && (phase == PH_W'(LAST_PH));
  assign loadNow   = !runEn || lastTick;
  assign cmd.run   = runEn;
  assign cmd.clear = !runEn;
  assign mSel      = setting[SET_W-1:NW];
  assign nSel      = setting[NW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setting <= RESET_BAUD[SET_W-1:0];
    else if (loadNow) setting <= baudIn[SET_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (!runEn) phase <= '0;
    else if (tick) phase <= lastTick ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else if (!runEn) begin
      stb <= '0;
    end else begin
      stb.sclLow    <= tick && (phase == PH_W'(LOW_PH));
      stb.sdaChange <= tick && (phase == PH_W'(CHG_PH));
      stb.sclHigh   <= tick && (phase == PH_W'(HIGH_PH));
      stb.sdaSample <= tick && (phase == PH_W'(SMP_PH));
    end
  end

  // R7: never two strobes together
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R6: disabled means quiet next cycle
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (stb == '0 && phase == '0));
  // R5: setting moves only when idle or at the period boundary
  a_r5_hold_setting: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !lastTick) |=> $stable(setting));
  // R3: tick index stays in range
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PH_W'(LAST_PH));
endmodule

// File: rtl/i2cBitClockGen.sv
module i2cBitClockGen
  import i2cClkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] baudByte,
  input  logic       runEn,
  output logic       sclLowStb,
  output logic       sdaChangeStb,
  output logic       sclHighStb,
  output logic       sdaSampleStb
);
  prescaleCmd_t  cmd;
  logic [M_W-1:0] mSel;
  logic [N_W-1:0] nSel;
  logic           tick;
  phaseStb_t      stb;

  i2cClkSeq #(.MW(M_W), .NW(N_W)) seqI (
    .clk(clk), .rstN(rstN), .baudIn(baudByte), .runEn(runEn),
    .tick(tick), .cmd(cmd), .mSel(mSel), .nSel(nSel), .stb(stb)
  );

  i2cClkPrescale #(.MW(M_W), .NW(N_W)) preI (
    .clk(clk), .rstN(rstN), .cmd(cmd), .mSel(mSel), .nSel(nSel),
    .tick(tick)
  );

  assign sclLowStb    = stb.sclLow;
  assign sdaChangeStb = stb.sdaChange;
  assign sclHighStb   = stb.sclHigh;
  assign sdaSampleStb = stb.sdaSample;
endmodule

// File: tb/i2cBitClockGen_test.sv
module i2cBitClockGen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] baudByte = 8'h00;
  logic       runEn = 1'b0;
  logic       sclLowStb, sdaChangeStb, sclHighStb, sdaSampleStb;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2cBitClockGen uut (
    .clk(clk), .rstN(rstN), .baudByte(baudByte), .runEn(runEn),
    .sclLowStb(sclLowStb), .sdaChangeStb(sdaChangeStb),
    .sclHighStb(sclHighStb), .sdaSampleStb(sdaSampleStb)
  );

  localparam int NV = 8;
  localparam logic [7:0] VB [NV] = '{8'h00, 8'h01, 8'h08, 8'h80,
                                     8'h0B, 8'h13, 8'h7B, 8'h7F};
  localparam int VP [NV] = '{1, 2, 2, 1, 16, 24, 128, 2048};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts at a negedge; edge k is the k-th posedge after the call
  task automatic measure(input int limit, input int chgAt, input logic [7:0] newBaud,
                         output int tLow, output int tChg, output int tHigh,
                         output int tSmp, output int tLow2, output int tChg2,
                         output int multi);
    tLow = -1; tChg = -1; tHigh = -1; tSmp = -1; tLow2 = -1; tChg2 = -1;
    multi = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (32'(sclLowStb) + 32'(sdaChangeStb) + 32'(sclHighStb) + 32'(sdaSampleStb) > 1)
        multi++;
      if (sclLowStb) begin
        if (tLow < 0) tLow = k; else if (tLow2 < 0) tLow2 = k;
      end
      if (sdaChangeStb) begin
        if (tChg < 0) tChg = k; else if (tChg2 < 0) tChg2 = k;
      end
      if (sclHighStb && tHigh < 0) tHigh = k;
      if (sdaSampleStb && tSmp < 0) tSmp = k;
      if (k == chgAt) baudByte = newBaud;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tl, tc, th, ts, tl2, tc2, mu, seen;
    // R8 and R4: enable held high through reset, input byte differs from 0x44
    runEn = 1'b1;
    baudByte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 strobes in reset", 32'({sclLowStb, sdaChangeStb, sclHighStb, sdaSampleStb}), 0);
    rstN = 1'b1;
    measure(1445, 0, 8'h00, tl, tc, th, ts, tl2, tc2, mu);
    chk("R4 first low at reset rate", tl, 144);
    chk("R4 sample at reset rate", ts, 8 * 144);
    chk("R5 next period uses taken byte", tl2, 1441);

    // table of rates
    for (int i = 0; i < NV; i++) begin
      runEn = 1'b0;
      baudByte = VB[i];
      @(negedge clk);
      runEn = 1'b1;
      measure(11 * VP[i] + 1, 0, VB[i], tl, tc, th, ts, tl2, tc2, mu);
      chk((VB[i][7]) ? "R2 bit7 ignored low" : "R1 first low", tl, VP[i]);
      chk("R3 sda change", tc, 3 * VP[i]);
      chk("R3 scl high", th, 6 * VP[i]);
      chk("R3 sda sample", ts, 8 * VP[i]);
      chk("R1 period", tl2, 11 * VP[i]);
      chk("R7 single strobe", mu, 0);
    end

    // R5: change mid-period at the fastest rate
    runEn = 1'b0;
    baudByte = 8'h00;
    @(negedge clk);
    runEn = 1'b1;
    measure(20, 3, 8'h01, tl, tc, th, ts, tl2, tc2, mu);
    chk("R5 old rate kept high", th, 6);
    chk("R5 new rate low", tl2, 12);
    chk("R5 new rate change", tc2, 16);

    // R6: disable mid-period, stay quiet, restart clean
    runEn = 1'b0;
    baudByte = 8'h13;
    @(negedge clk);
    runEn = 1'b1;
    repeat (40) @(negedge clk);
    runEn = 1'b0;
    baudByte = 8'h00;
    @(negedge clk);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sclLowStb || sdaChangeStb || sclHighStb || sdaSampleStb) seen++;
    end
    chk("R6 quiet when disabled", seen, 0);
    baudByte = 8'h13;
    @(negedge clk);
    runEn = 1'b1;
    measure(80, 0, 8'h13, tl, tc, th, ts, tl2, tc2, mu);
    chk("R6 restart low", tl, 24);
    chk("R6 restart change", tc, 72);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule